// File: doc/BRIEF.md
# Vector Micro-op Split Queue

This block sits between a three-slot instruction decoder and a back end whose datapath is 64 bits wide. A 128-bit vector operation reaches it as a single laminated micro-op. Because the pair takes one queue entry, the decoder can hand over three vector operations per cycle. The block keeps the entries in arrival order. On the read side it issues each laminated entry as two 64-bit micro-ops with the same payload: first the low half, then the high half. A scalar entry issues once.

The queue counts its occupancy in entries, not in issued micro-ops. It drives a clock-gate request to the front end, and that request has hysteresis. The request rises once occupancy has gone above a high mark. It falls only when occupancy has come down to a low mark or below it. This lets the front end sleep while the back end works through a backlog. A flush input discards everything, including a laminated entry whose low half has already issued.

Top module: `uop_split_queue`

## Requirements
- R1: After reset the queue is empty: out_valid=0, out_half=0, fe_gate=0 and in_ready=1.
- R2: In a cycle where in_ready=1, every slot whose in_valid bit is set is stored. Slot 0 is placed before slot 1, and slot 1 before slot 2. Slots whose valid bit is clear are skipped, and order is preserved across cycles.
- R3: in_ready is 1 exactly when at least three entries are free. Slot writes offered while in_ready=0 are discarded and never issue.
- R4: An entry with its laminated flag clear (in_lam bit = 0) issues once, with out_half=0.
- R5: An entry with its laminated flag set issues twice, on consecutive handshakes, with the same payload. The first issue has out_half=0 and the second has out_half=1. The entry frees only after the second issue.
- R6: While out_valid=1 and out_ready=0, out_payload and out_half hold their values.
- R7: Occupancy counts entries. A laminated entry occupies one entry no matter how many halves remain to issue.
- R8: At each clock edge fe_gate updates from the occupancy held before that edge. It becomes 1 if occupancy > hi_mark, becomes 0 if occupancy <= lo_mark, and otherwise keeps its value.
- R9: flush=1 empties the queue, drops any pending high half and clears fe_gate at the same edge. Slot writes offered in that cycle are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Discard all contents |
| in_valid | input | 3 | Per-slot write valid; bit i belongs to slot i |
| in_lam | input | 3 | Per-slot laminated flag |
| in_payload | input | 3*UOP_W | Slot i payload at bits [i*UOP_W +: UOP_W] |
| in_ready | output | 1 | Room for three entries |
| hi_mark | input | CW | Gate-set threshold (occupancy strictly above) |
| lo_mark | input | CW | Gate-clear threshold (occupancy at or below) |
| out_valid | output | 1 | Issue port holds a micro-op |
| out_ready | input | 1 | Back end takes the micro-op |
| out_payload | output | UOP_W | Payload of issued micro-op |
| out_half | output | 1 | 0 = low half or scalar, 1 = high half |
| fe_gate | output | 1 | Front-end clock-gate request |

## Verification
The bench builds the block with DEPTH=8, UOP_W=16, hi_mark=4 and lo_mark=1. With a depth of eight, two full three-slot writes are enough to push occupancy to six. At six, in_ready drops and the gate request rises within a few cycles. The gap between the two marks is wide enough to observe the request holding its value at occupancies two, three and four before it falls at one. Mixed laminated and scalar traffic, with a random back-pressure pattern, covers slot skipping, split ordering and stall hold. A flush taken between the two halves of a pair is also exercised.

// File: rtl/uop_split_queue.sv
module uop_split_queue #(
  parameter int DEPTH = 8,
  parameter int UOP_W = 16,
  localparam int PW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush,
  input  logic [2:0]         in_valid,
  input  logic [2:0]         in_lam,
  input  logic [3*UOP_W-1:0] in_payload,
  output logic               in_ready,
  input  logic [CW-1:0]      hi_mark,
  input  logic [CW-1:0]      lo_mark,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [UOP_W-1:0]   out_payload,
  output logic               out_half,
  output logic               fe_gate
);

  logic [UOP_W-1:0] pay_q [DEPTH];
  logic [DEPTH-1:0] lam_q;
  logic [PW-1:0]    wr_ptr, rd_ptr;
  logic [CW-1:0]    occ;
  logic             half_q, gate_q;

  wire accept = in_ready && (|in_valid) && !flush;
  wire fire   = out_valid && out_ready && !flush;
  wire pop    = fire && (!lam_q[rd_ptr] || half_q);

  wire [PW-1:0] off1 = PW'(in_valid[0]);
  wire [PW-1:0] off2 = PW'(in_valid[0]) + PW'(in_valid[1]);
  wire [CW-1:0] nwr  = accept ? (CW'(in_valid[0]) + CW'(in_valid[1]) + CW'(in_valid[2])) : '0;

  assign in_ready    = occ <= CW'(DEPTH - 3);
  assign out_valid   = occ != '0;
  assign out_payload = pay_q[rd_ptr];
  assign out_half    = half_q;
  assign fe_gate     = gate_q;

  always_ff @(posedge clk) begin
    if (accept) begin
      if (in_valid[0]) begin
        pay_q[wr_ptr] <= in_payload[0 +: UOP_W];
        lam_q[wr_ptr] <= in_lam[0];
      end
      if (in_valid[1]) begin
        pay_q[wr_ptr + off1] <= in_payload[UOP_W +: UOP_W];
        lam_q[wr_ptr + off1] <= in_lam[1];
      end
      if (in_valid[2]) begin
        pay_q[wr_ptr + off2] <= in_payload[2*UOP_W +: UOP_W];
        lam_q[wr_ptr + off2] <= in_lam[2];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      occ    <= '0;
      half_q <= 1'b0;
      gate_q <= 1'b0;
    end else begin
      wr_ptr <= wr_ptr + PW'(nwr);
      occ    <= occ + nwr - CW'(pop);
      if (pop) begin
        rd_ptr <= rd_ptr + 1'b1;
        half_q <= 1'b0;
      end else if (fire) begin
        half_q <= 1'b1;
      end
      if (occ > hi_mark)       gate_q <= 1'b1;
      else if (occ <= lo_mark) gate_q <= 1'b0;
    end
  end

endmodule

// File: rtl/uop_split_queue_chk.sv
module uop_split_queue_chk #(
  parameter int DEPTH = 8,
  parameter int UOP_W = 16,
  parameter int CW = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             flush,
  input logic             out_valid,
  input logic             out_ready,
  input logic [UOP_W-1:0] out_payload,
  input logic             out_half,
  input logic             fe_gate,
  input logic [CW-1:0]    occ,
  input logic [CW-1:0]    hi_mark,
  input logic [CW-1:0]    lo_mark
);

  // R9
  flush_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !out_valid && !out_half && !fe_gate);

  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready && !flush |=> out_valid && $stable(out_payload) && $stable(out_half));

  // R5
  half_after_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_half) |-> $past(out_valid && out_ready && !flush) && $stable(out_payload));

  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= CW'(DEPTH));

  // R8
  gate_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fe_gate) |-> $past(occ > hi_mark));

  // R8
  gate_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fe_gate) && !$past(flush) |-> $past(occ <= lo_mark));

endmodule

bind uop_split_queue uop_split_queue_chk #(.DEPTH(DEPTH), .UOP_W(UOP_W), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .out_valid(out_valid), .out_ready(out_ready),
  .out_payload(out_payload), .out_half(out_half), .fe_gate(fe_gate), .occ(occ),
  .hi_mark(hi_mark), .lo_mark(lo_mark)
);

// File: tb/tb_uop_split_queue.sv
module tb_uop_split_queue;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 8;
  localparam int W = 16;
  localparam int CW = $clog2(DEPTH + 1);

  logic clk = 0, rst_n = 0, flush = 0;
  logic [2:0] in_valid = 0, in_lam = 0;
  logic [3*W-1:0] in_payload = 0;
  logic in_ready, out_valid, out_half, fe_gate;
  logic out_ready = 0;
  logic [W-1:0] out_payload;
  logic [CW-1:0] hi_mark = CW'(4), lo_mark = CW'(1);

  int checks = 0, errors = 0;
  logic [W:0] exp_q[$];
  logic [W-1:0] seq = 16'h100;
  bit wr_done;

  always #(CLK_PERIOD/2) clk = ~clk;

  uop_split_queue #(.DEPTH(DEPTH), .UOP_W(W)) dut (
    .clk(clk), .rst_n(rst_n), .flush(flush), .in_valid(in_valid), .in_lam(in_lam),
    .in_payload(in_payload), .in_ready(in_ready), .hi_mark(hi_mark), .lo_mark(lo_mark),
    .out_valid(out_valid), .out_ready(out_ready), .out_payload(out_payload),
    .out_half(out_half), .fe_gate(fe_gate));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic write3(input logic [2:0] v, input logic [2:0] l);
    while (!in_ready) tick();
    for (int i = 0; i < 3; i++) begin
      in_payload[i*W +: W] = seq;
      if (v[i]) begin
        exp_q.push_back({1'b0, seq});
        if (l[i]) exp_q.push_back({1'b1, seq});
      end
      seq++;
    end
    in_valid = v;
    in_lam = l;
    tick();
    in_valid = 0;
  endtask

  task automatic drain();
    out_ready = 1;
    while (out_valid) tick();
    out_ready = 0;
  endtask

  always @(negedge clk) begin
    if (rst_n && !flush && out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        chk(0, "R3 unexpected issue", {15'd0, out_half, out_payload}, 0);
      end else begin
        logic [W:0] e;
        e = exp_q.pop_front();
        // R2 R4 R5 order, payload and half select
        chk({out_half, out_payload} == e, "R2/R4/R5 issue", {15'd0, out_half, out_payload}, {15'd0, e});
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst_n = 1;
    tick();
    // R1
    chk(!out_valid, "R1 out_valid", out_valid, 0);
    chk(!out_half, "R1 out_half", out_half, 0);
    chk(!fe_gate, "R1 fe_gate", fe_gate, 0);
    chk(in_ready, "R1 in_ready", in_ready, 1);

    // R2 slot skipping, R4 scalar, R5 split
    write3(3'b101, 3'b001);
    write3(3'b010, 3'b010);
    chk(out_valid && !out_half, "R5 low first", out_half, 0);
    out_ready = 1; tick(); out_ready = 0;
    chk(out_half && out_payload == 16'h100, "R5 high second", {15'd0, out_half, out_payload}, 32'h1_0100);
    tick();
    // R6
    chk(out_half && out_payload == 16'h100, "R6 hold", {15'd0, out_half, out_payload}, 32'h1_0100);
    drain();
    chk(exp_q.size() == 0, "R2 all issued", exp_q.size(), 0);

    // R3 R8 watermark with scalars
    write3(3'b111, 3'b000);
    write3(3'b111, 3'b000);
    chk(!in_ready, "R3 ready low at six", in_ready, 0);
    chk(!fe_gate, "R8 gate lags", fe_gate, 0);
    in_payload = {3{16'hDEAD}};
    in_valid = 3'b111; tick(); in_valid = 0;
    chk(fe_gate, "R8 gate set above hi", fe_gate, 1);
    out_ready = 1; repeat (4) tick(); out_ready = 0;
    tick();
    chk(fe_gate, "R8 hold between marks", fe_gate, 1);
    out_ready = 1; tick(); out_ready = 0;
    chk(fe_gate, "R8 still set", fe_gate, 1);
    tick();
    chk(!fe_gate, "R8 clear at lo", fe_gate, 0);
    drain();
    chk(exp_q.size() == 0 && !out_valid, "R3 dropped writes never issue", exp_q.size(), 0);

    // R7 laminated entries count once
    write3(3'b111, 3'b111);
    write3(3'b111, 3'b111);
    chk(!in_ready, "R7 six laminated entries fill", in_ready, 0);
    out_ready = 1; tick();
    chk(!in_ready, "R7 entry kept after low half", in_ready, 0);
    tick();
    chk(in_ready, "R7 entry freed after high half", in_ready, 1);
    tick(); out_ready = 0;
    chk(out_half && fe_gate, "R9 pre-flush state", {out_half, fe_gate}, 3);

    // R9
    flush = 1; in_valid = 3'b111; exp_q.delete();
    tick();
    flush = 0; in_valid = 0;
    chk(!out_valid, "R9 empty", out_valid, 0);
    chk(!out_half, "R9 half dropped", out_half, 0);
    chk(!fe_gate, "R9 gate cleared", fe_gate, 0);
    chk(in_ready, "R9 ready", in_ready, 1);
    tick();
    chk(!out_valid, "R9 flush-cycle write dropped", out_valid, 0);

    // mixed traffic with random back-pressure
    wr_done = 0;
    fork
      begin
        for (int k = 0; k < 60; k++) write3(3'($urandom_range(1, 7)), 3'($urandom_range(0, 7)));
        wr_done = 1;
      end
      begin
        while (!wr_done || out_valid) begin
          out_ready = ($urandom_range(0, 3) != 0);
          tick();
        end
        out_ready = 0;
      end
    join
    chk(exp_q.size() == 0, "R2/R6 mixed traffic complete", exp_q.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule